// File: doc/BRIEF.md
# Two-Share Masked AND / AND-XOR Gate

This block computes a bitwise AND, or an AND followed by an XOR, on data held as two Boolean shares. Every operand word `a` is carried as a pair `a0`, `a1` with `a = a0 ^ a1`, and no node of the datapath ever combines both shares of the same operand product. All `WIDTH` bit positions of a word are handled side by side and independently of one another. The gate is meant to serve as the nonlinear step of a masked adder or other mixing logic, where it is placed once per prefix level.

The gate forms the four share cross products. It adds a guard value to the two products that feed different output shares, registers the guarded products together with the two unguarded ones, and then folds the four registered terms into two output shares. In plain AND mode the guard is one fresh random bit, copied to every lane. In AND-XOR mode the two shares of the third operand take the place of the guard, so that the XOR comes for free and no fresh bit is needed. A result appears one clock after its input is accepted, together with a valid flag.

Top module: `masked_and2_gadget`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `z0` and `z1` are all zero.
- R2: With `mode` = 0 (AND) and `in_valid` = 1, then one cycle later `z0 ^ z1 == (x0 ^ x1) & (y0 ^ y1)` in every bit position.
- R3: With `mode` = 1 (AND-XOR) and `in_valid` = 1, then one cycle later `z0 ^ z1 == ((x0 ^ x1) & (y0 ^ y1)) ^ (w0 ^ w1)` in every bit position.
- R4: The recombined output `z0 ^ z1` does not depend on `m` in either mode. In AND-XOR mode `m` affects neither share, and in AND mode `w0`/`w1` affect neither share.
- R5: In AND mode the individual output shares are `z0 = (x0&y0) ^ (x1&y0) ^ {WIDTH{m}}` and `z1 = (x0&y1) ^ (x1&y1) ^ {WIDTH{m}}`. In AND-XOR mode they are `z0 = (x0&y0) ^ (x1&y0) ^ w0` and `z1 = (x0&y1) ^ (x1&y1) ^ w1`.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock.
- R7: In a cycle where `in_valid` is 0, the inputs are ignored, and one cycle later `z0` and `z1` still hold their previous values.
- R8: Each bit lane depends only on the inputs at its own bit position, so lanes driven with different share patterns in the same word each follow R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word is valid and is captured this cycle |
| mode | input | 1 | 0: AND, 1: AND-XOR with operand w |
| m | input | 1 | Fresh guard bit used in AND mode |
| x0 | input | WIDTH | Share 0 of operand x |
| x1 | input | WIDTH | Share 1 of operand x |
| y0 | input | WIDTH | Share 0 of operand y |
| y1 | input | WIDTH | Share 1 of operand y |
| w0 | input | WIDTH | Share 0 of the XOR operand w |
| w1 | input | WIDTH | Share 1 of the XOR operand w |
| z0 | output | WIDTH | Result share 0 |
| z1 | output | WIDTH | Result share 1 |
| out_valid | output | 1 | Result shares are valid |

## Verification
Every result is due one rising edge after the edge that captures the input. The bench changes inputs on the falling edge and reads `z0`, `z1` and `out_valid` on the next falling edge, which falls half a period after the capturing edge. A sweep covers all 64 combinations of the six share bits, with a different combination in each lane of the word, for both values of `m` and both modes. It checks the individual shares and their XOR against formulas computed in the bench. Idle cycles are checked for held shares and a low valid flag on the falling edge after the idle edge. Runs that differ only in `m`, or only in `w` in AND mode, are compared result against result.

// File: rtl/masked_and2_pkg.sv
package masked_and2_pkg;

  typedef enum logic {
    GATE_AND    = 1'b0,
    GATE_ANDXOR = 1'b1
  } gate_mode_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/mand_rst_sync.sv
module mand_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mand_cross.sv
module mand_cross #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x0,
  input  logic [WIDTH-1:0] x1,
  input  logic [WIDTH-1:0] y0,
  input  logic [WIDTH-1:0] y1,
  output logic [WIDTH-1:0] p00,
  output logic [WIDTH-1:0] p01,
  output logic [WIDTH-1:0] p10,
  output logic [WIDTH-1:0] p11
);

  // One independent product cell per bit lane.
  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    assign p00[b] = x0[b] & y0[b];
    assign p01[b] = x0[b] & y1[b];
    assign p10[b] = x1[b] & y0[b];
    assign p11[b] = x1[b] & y1[b];
  end

endmodule

// File: rtl/mand_guard.sv
module mand_guard
  import masked_and2_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  gate_mode_e       mode,
  input  logic             m,
  input  logic [WIDTH-1:0] w0,
  input  logic [WIDTH-1:0] w1,
  input  logic [WIDTH-1:0] p00,
  input  logic [WIDTH-1:0] p01,
  output logic [WIDTH-1:0] t0,
  output logic [WIDTH-1:0] t1
);

  logic [WIDTH-1:0] guard0;
  logic [WIDTH-1:0] guard1;

  // Guard selection: one fresh bit spread over the word, or the w shares.
  always_comb begin
    unique case (mode)
      GATE_ANDXOR: begin
        guard0 = w0;
        guard1 = w1;
      end
      default: begin
        guard0 = {WIDTH{m}};
        guard1 = {WIDTH{m}};
      end
    endcase
  end

  // Guard is applied ahead of the register stage.
  assign t0 = p00 ^ guard0;
  assign t1 = p01 ^ guard1;

endmodule

// File: rtl/mand_stage.sv
module mand_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] t0,
  input  logic [WIDTH-1:0] t1,
  input  logic [WIDTH-1:0] p10,
  input  logic [WIDTH-1:0] p11,
  output logic [WIDTH-1:0] t0_q,
  output logic [WIDTH-1:0] t1_q,
  output logic [WIDTH-1:0] p10_q,
  output logic [WIDTH-1:0] p11_q,
  output logic             valid_q
);

  logic [WIDTH-1:0] t0_d;
  logic [WIDTH-1:0] t1_d;
  logic [WIDTH-1:0] p10_d;
  logic [WIDTH-1:0] p11_d;
  logic             load_en;

  assign load_en = in_valid;

  always_comb begin
    t0_d  = t0_q;
    t1_d  = t1_q;
    p10_d = p10_q;
    p11_d = p11_q;
    if (load_en) begin
      t0_d  = t0;
      t1_d  = t1;
      p10_d = p10;
      p11_d = p11;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_q  <= '0;
      t1_q  <= '0;
      p10_q <= '0;
      p11_q <= '0;
    end else begin
      t0_q  <= t0_d;
      t1_q  <= t1_d;
      p10_q <= p10_d;
      p11_q <= p11_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

endmodule

// File: rtl/mand_compress.sv
module mand_compress #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] t0_q,
  input  logic [WIDTH-1:0] t1_q,
  input  logic [WIDTH-1:0] p10_q,
  input  logic [WIDTH-1:0] p11_q,
  output logic [WIDTH-1:0] z0,
  output logic [WIDTH-1:0] z1
);

  // Each output share draws only on registered terms of its own column.
  assign z0 = t0_q ^ p10_q;
  assign z1 = t1_q ^ p11_q;

endmodule

// File: rtl/masked_and2_gadget.sv
module masked_and2_gadget
  import masked_and2_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             mode,
  input  logic             m,
  input  logic [WIDTH-1:0] x0,
  input  logic [WIDTH-1:0] x1,
  input  logic [WIDTH-1:0] y0,
  input  logic [WIDTH-1:0] y1,
  input  logic [WIDTH-1:0] w0,
  input  logic [WIDTH-1:0] w1,
  output logic [WIDTH-1:0] z0,
  output logic [WIDTH-1:0] z1,
  output logic             out_valid
);

  logic             rst_sync_n;
  gate_mode_e       mode_e;
  logic [WIDTH-1:0] p00;
  logic [WIDTH-1:0] p01;
  logic [WIDTH-1:0] p10;
  logic [WIDTH-1:0] p11;
  logic [WIDTH-1:0] t0;
  logic [WIDTH-1:0] t1;
  logic [WIDTH-1:0] t0_q;
  logic [WIDTH-1:0] t1_q;
  logic [WIDTH-1:0] p10_q;
  logic [WIDTH-1:0] p11_q;

  assign mode_e = gate_mode_e'(mode);

  mand_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  mand_cross #(
    .WIDTH(WIDTH)
  ) u_cross (
    .x0 (x0),
    .x1 (x1),
    .y0 (y0),
    .y1 (y1),
    .p00(p00),
    .p01(p01),
    .p10(p10),
    .p11(p11)
  );

  mand_guard #(
    .WIDTH(WIDTH)
  ) u_guard (
    .mode(mode_e),
    .m   (m),
    .w0  (w0),
    .w1  (w1),
    .p00 (p00),
    .p01 (p01),
    .t0  (t0),
    .t1  (t1)
  );

  mand_stage #(
    .WIDTH(WIDTH)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_valid(in_valid),
    .t0      (t0),
    .t1      (t1),
    .p10     (p10),
    .p11     (p11),
    .t0_q    (t0_q),
    .t1_q    (t1_q),
    .p10_q   (p10_q),
    .p11_q   (p11_q),
    .valid_q (out_valid)
  );

  mand_compress #(
    .WIDTH(WIDTH)
  ) u_compress (
    .t0_q (t0_q),
    .t1_q (t1_q),
    .p10_q(p10_q),
    .p11_q(p11_q),
    .z0   (z0),
    .z1   (z1)
  );

endmodule

// File: rtl/masked_and2_gadget_chk.sv
module masked_and2_gadget_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic             mode,
  input logic             m,
  input logic [WIDTH-1:0] x0,
  input logic [WIDTH-1:0] x1,
  input logic [WIDTH-1:0] y0,
  input logic [WIDTH-1:0] y1,
  input logic [WIDTH-1:0] w0,
  input logic [WIDTH-1:0] w1,
  input logic [WIDTH-1:0] z0,
  input logic [WIDTH-1:0] z1,
  input logic             out_valid
);

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!out_valid && z0 == '0 && z1 == '0)
        else $error("p_reset_clear_r1");
    end
  end

  p_and_func_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !mode) |=> ((z0 ^ z1) == $past((x0 ^ x1) & (y0 ^ y1))))
    else $error("p_and_func_r2");

  p_andxor_func_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mode) |=>
      ((z0 ^ z1) == $past(((x0 ^ x1) & (y0 ^ y1)) ^ (w0 ^ w1))))
    else $error("p_andxor_func_r3");

  // R4: in AND-XOR mode share 0 is fixed by x, y and w alone, never by m
  p_xor_share0_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mode) |=> (z0 == $past((x0 & y0) ^ (x1 & y0) ^ w0)))
    else $error("p_xor_share0_r4");

  p_xor_share1_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mode) |=> (z1 == $past((x0 & y1) ^ (x1 & y1) ^ w1)))
    else $error("p_xor_share1_r5");

  p_and_share0_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !mode) |=> (z0 == $past((x0 & y0) ^ (x1 & y0) ^ {WIDTH{m}})))
    else $error("p_and_share0_r5");

  p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid)
    else $error("p_valid_set_r6");

  p_valid_clr_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid)
    else $error("p_valid_clr_r6");

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(z0) && $stable(z1)))
    else $error("p_hold_idle_r7");

endmodule

bind masked_and2_gadget masked_and2_gadget_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/masked_and2_gadget_bench.sv
module masked_and2_gadget_bench;

  localparam int unsigned BW = 4;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          mode;
  logic          m;
  logic [BW-1:0] x0, x1, y0, y1, w0, w1;
  logic [BW-1:0] z0, z1;
  logic          out_valid;

  int checks;
  int failures;
  bit done;

  masked_and2_gadget #(.WIDTH(BW)) u_masked_and2_gadget (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (mode),
    .m        (m),
    .x0       (x0),
    .x1       (x1),
    .y0       (y0),
    .y1       (y1),
    .w0       (w0),
    .w1       (w1),
    .z0       (z0),
    .z1       (z1),
    .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Lane j of the word carries combination (c + 17*j) mod 64:
  // bit0 x0, bit1 x1, bit2 y0, bit3 y1, bit4 w0, bit5 w1.
  task automatic load_combo(input int c);
    for (int j = 0; j < int'(BW); j++) begin
      int cj;
      cj = (c + 17 * j) % 64;
      x0[j] = cj[0];
      x1[j] = cj[1];
      y0[j] = cj[2];
      y1[j] = cj[3];
      w0[j] = cj[4];
      w1[j] = cj[5];
    end
  endtask

  task automatic expect_shares(output logic [BW-1:0] e0, output logic [BW-1:0] e1);
    logic [BW-1:0] g0, g1;
    g0 = mode ? w0 : {BW{m}};
    g1 = mode ? w1 : {BW{m}};
    e0 = (x0 & y0) ^ (x1 & y0) ^ g0;
    e1 = (x0 & y1) ^ (x1 & y1) ^ g1;
  endtask

  initial begin
    logic [BW-1:0] e0, e1, ez, hz0, hz1, ref0, ref1;
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mode     = 1'b0;
    m        = 1'b0;
    x0 = '0; x1 = '0; y0 = '0; y1 = '0; w0 = '0; w1 = '0;

    repeat (3) @(negedge clk);
    // R1: reset state, with inputs active
    in_valid = 1'b1;
    x0 = '1; y0 = '1;
    @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 z0", 32'(z0), 32'd0);
    check("R1 z1", 32'(z1), 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Exhaustive sweep: R2, R3, R5, R6, R8
    for (int md = 0; md < 2; md++) begin
      for (int mb = 0; mb < 2; mb++) begin
        for (int c = 0; c < 64; c++) begin
          mode = md[0];
          m    = mb[0];
          load_combo(c);
          in_valid = 1'b1;
          expect_shares(e0, e1);
          ez = (x0 ^ x1) & (y0 ^ y1);
          if (md == 1) ez = ez ^ w0 ^ w1;
          @(negedge clk);
          check("R6 out_valid after accept", 32'(out_valid), 32'd1);
          if (md == 0) check("R2 AND recombined (R8 lanes)", 32'(z0 ^ z1), 32'(ez));
          else         check("R3 AND-XOR recombined (R8 lanes)", 32'(z0 ^ z1), 32'(ez));
          check("R5 share z0", 32'(z0), 32'(e0));
          check("R5 share z1", 32'(z1), 32'(e1));
        end
      end
    end

    // R7: idle cycles ignore inputs and hold shares; R6 valid drops
    hz0 = z0;
    hz1 = z1;
    in_valid = 1'b0;
    x0 = 4'hA; x1 = 4'h3; y0 = 4'hF; y1 = 4'h6; m = ~m; mode = ~mode;
    @(negedge clk);
    check("R6 out_valid after idle", 32'(out_valid), 32'd0);
    check("R7 z0 held", 32'(z0), 32'(hz0));
    check("R7 z1 held", 32'(z1), 32'(hz1));
    x0 = 4'h5; w0 = 4'h9;
    @(negedge clk);
    check("R7 z0 held second idle", 32'(z0), 32'(hz0));
    check("R7 z1 held second idle", 32'(z1), 32'(hz1));

    // R4: m has no effect on z0^z1 in AND mode
    for (int c = 0; c < 64; c += 5) begin
      mode = 1'b0; load_combo(c); in_valid = 1'b1; m = 1'b0;
      @(negedge clk);
      ref0 = z0 ^ z1;
      m = 1'b1;
      @(negedge clk);
      check("R4 AND recombined independent of m", 32'(z0 ^ z1), 32'(ref0));
    end
    // R4: AND-XOR mode, m touches neither share
    for (int c = 3; c < 64; c += 7) begin
      mode = 1'b1; load_combo(c); in_valid = 1'b1; m = 1'b0;
      @(negedge clk);
      ref0 = z0; ref1 = z1;
      m = 1'b1;
      @(negedge clk);
      check("R4 AND-XOR z0 independent of m", 32'(z0), 32'(ref0));
      check("R4 AND-XOR z1 independent of m", 32'(z1), 32'(ref1));
    end
    // R4: AND mode, w touches neither share
    for (int c = 1; c < 64; c += 9) begin
      mode = 1'b0; load_combo(c); in_valid = 1'b1; m = c[1];
      @(negedge clk);
      ref0 = z0; ref1 = z1;
      w0 = ~w0; w1 = w1 ^ 4'h5;
      @(negedge clk);
      check("R4 AND z0 independent of w", 32'(z0), 32'(ref0));
      check("R4 AND z1 independent of w", 32'(z1), 32'(ref1));
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1..R8 run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule